// File: doc/BRIEF.md
# Sized Bitwise-OR Execute Stage

This block is the execute step of an integer pipeline for the inclusive-OR operation. A request carries the current 64-bit destination register value, a second operand, an operand size of 8, 16, 32 or 64 bits, and the incoming status flags. The second operand is either a register value or a raw immediate that is 8 or 32 bits wide. The stage extends the immediate to the operand size and ORs the two operands at that size. It then computes the status flags from the sized result and merges the result back into the full 64-bit register image. For byte operations, the merge can target the second byte of the register instead of the lowest one.

Requests arrive on a valid/ready stream and results leave on a valid/ready stream. The result is held in a single output register. A request is taken on any clock edge where `in_valid` and `in_ready` are both high, and its result appears on the next cycle. `in_ready` is high when the output register is empty or is being emptied in the same cycle. While `out_valid` is high and `out_ready` is low, the result and flags stay frozen and no new request is taken. Memory operands, atomic locking and fault reporting belong to other blocks.

Top module: `or_exec_unit`

## Requirements
- R1: Each result bit inside the operand size is 0 only when both operand bits are 0. Size code 0 = 8 bits, 1 = 16, 2 = 32, 3 = 64. A register source is read from its low bits.
- R2: Immediates are extended before use, when `in_src_imm` is 1.
  - Short form (`in_imm_short` = 1), size above 8 bits, `in_sext` = 1: imm[7:0] is sign-extended.
  - Short form, `in_sext` = 0: imm[7:0] is zero-extended.
  - Long form at size 64: imm[31:0] is always sign-extended.
  - Long form at smaller sizes: imm[31:0] is truncated to the operand size.
- R3: The carry flag (flag bit 0) and the overflow flag (flag bit 5) are always 0 in the output.
- R4: The zero flag (bit 3) is 1 exactly when the sized result is all zeros. The sign flag (bit 4) equals the top bit of the sized result.
- R5: The parity flag (bit 1) is 1 when the low 8 bits of the sized result hold an even number of ones.
- R6: The auxiliary flag (bit 2) is copied unchanged from `in_flags`.
- R7: At sizes 8 and 16, the register bits above the operand size keep their `in_dst` values.
- R8: At size 32, bits 63:32 of `out_result` are 0.
- R9: At size 8 with `in_hi_byte` = 1, the destination operand is `in_dst[15:8]` and the result is written there. All other bits keep their `in_dst` values. At other sizes, `in_hi_byte` has no effect.
- R10: A request accepted on a clock edge drives `out_valid` and its result on the following cycle.
- R11: While `out_valid` = 1 and `out_ready` = 0, `in_ready` is 0 and `out_result` and `out_flags` hold their values.
- R12: After reset, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be taken this cycle |
| in_dst | input | 64 | Current destination register value |
| in_src | input | 64 | Register source operand |
| in_imm | input | 32 | Raw immediate |
| in_src_imm | input | 1 | 1 selects the immediate as the source |
| in_imm_short | input | 1 | 1 means only imm[7:0] is meaningful |
| in_sext | input | 1 | Sign-extend a short immediate |
| in_size | input | 2 | Operand size code |
| in_hi_byte | input | 1 | Byte operation on bits 15:8 |
| in_flags | input | 6 | Incoming status flags |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_result | output | 64 | Merged destination register value |
| out_flags | output | 6 | Updated status flags |

## Verification
The bench targets the corner cases most likely to be wrong:
- An immediate of 0x80 at several sizes, with and without sign extension. A wrong extension shows up as missing or extra ones above bit 7.
- A long immediate with its top bit set at size 64, where a missing extension leaves the upper half clear.
- An all-ones register at size 32, which exposes a merge that keeps the old upper half instead of clearing it.
- Byte operations on bits 15:8, where an offset error lands the result in the wrong byte.

It also checks that the zero and sign flags follow the operand size rather than the whole 64 bits. Stalled outputs must stay frozen, and no request may be taken while the result is held.

// File: rtl/or_exec_pkg.sv
package or_exec_pkg;
  localparam int REG_W  = 64;
  localparam int IMM_W  = 32;
  localparam int FLAG_W = 6;
  localparam int NUM_SZ = 4;

  localparam int FL_CARRY  = 0;
  localparam int FL_PARITY = 1;
  localparam int FL_AUX    = 2;
  localparam int FL_ZERO   = 3;
  localparam int FL_SIGN   = 4;
  localparam int FL_OVER   = 5;

  typedef enum logic [1:0] {
    OPSZ_8  = 2'd0,
    OPSZ_16 = 2'd1,
    OPSZ_32 = 2'd2,
    OPSZ_64 = 2'd3
  } opsz_e;

  function automatic logic [REG_W-1:0] size_mask(input logic [1:0] sz);
    logic [REG_W-1:0] m;
    case (sz)
      OPSZ_8:  m = {{(REG_W-8){1'b0}}, 8'hFF};
      OPSZ_16: m = {{(REG_W-16){1'b0}}, 16'hFFFF};
      OPSZ_32: m = {{(REG_W-32){1'b0}}, 32'hFFFF_FFFF};
      default: m = {REG_W{1'b1}};
    endcase
    return m;
  endfunction
endpackage

// File: rtl/or_imm_extend.sv
module or_imm_extend
  import or_exec_pkg::*;
#(
  parameter int W  = REG_W,
  parameter int IW = IMM_W
) (
  input  logic [IW-1:0] imm,
  input  logic          short_form,
  input  logic          sext,
  input  logic [1:0]    size,
  output logic [W-1:0]  ext
);
  localparam int PAD_S = W - 8;
  localparam int PAD_L = W - IW;

  logic [W-1:0] short_val;
  logic [W-1:0] long_val;

  always_comb begin
    if (sext && size != OPSZ_8)
      short_val = {{PAD_S{imm[7]}}, imm[7:0]};
    else
      short_val = {{PAD_S{1'b0}}, imm[7:0]};
    if (size == OPSZ_64)
      long_val = {{PAD_L{imm[IW-1]}}, imm};
    else
      long_val = {{PAD_L{1'b0}}, imm};
    ext = (short_form ? short_val : long_val) & size_mask(size);
  end
endmodule

// File: rtl/or_sized_core.sv
module or_sized_core
  import or_exec_pkg::*;
#(
  parameter int W = REG_W
) (
  input  logic [W-1:0] dst,
  input  logic [W-1:0] src,
  input  logic [1:0]   size,
  input  logic         hi_byte,
  output logic [W-1:0] res,
  output logic         zero,
  output logic         sign,
  output logic         parity
);
  logic [W-1:0] a_op;
  logic [W-1:0] b_op;
  logic [NUM_SZ-1:0] zero_by_sz;
  logic [NUM_SZ-1:0] sign_by_sz;

  always_comb begin
    if (hi_byte && size == OPSZ_8)
      a_op = {{(W-8){1'b0}}, dst[15:8]};
    else
      a_op = dst & size_mask(size);
    b_op = src & size_mask(size);
    res  = a_op | b_op;
  end

  for (genvar g = 0; g < NUM_SZ; g++) begin : g_lane
    localparam int LW = 8 << g;
    assign zero_by_sz[g] = ~|res[LW-1:0];
    assign sign_by_sz[g] = res[LW-1];
  end

  assign zero   = zero_by_sz[size];
  assign sign   = sign_by_sz[size];
  assign parity = ~^res[7:0];
endmodule

// File: rtl/or_reg_merge.sv
module or_reg_merge
  import or_exec_pkg::*;
#(
  parameter int W = REG_W
) (
  input  logic [W-1:0] dst,
  input  logic [W-1:0] res,
  input  logic [1:0]   size,
  input  logic         hi_byte,
  output logic [W-1:0] merged
);
  always_comb begin
    case (size)
      OPSZ_8: begin
        if (hi_byte) merged = {dst[W-1:16], res[7:0], dst[7:0]};
        else         merged = {dst[W-1:8], res[7:0]};
      end
      OPSZ_16: merged = {dst[W-1:16], res[15:0]};
      OPSZ_32: merged = {{(W-32){1'b0}}, res[31:0]};
      default: merged = res;
    endcase
  end
endmodule

// File: rtl/or_exec_unit.sv
module or_exec_unit
  import or_exec_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [63:0]       in_dst,
  input  logic [63:0]       in_src,
  input  logic [31:0]       in_imm,
  input  logic              in_src_imm,
  input  logic              in_imm_short,
  input  logic              in_sext,
  input  logic [1:0]        in_size,
  input  logic              in_hi_byte,
  input  logic [5:0]        in_flags,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [63:0]       out_result,
  output logic [5:0]        out_flags
);
  logic [REG_W-1:0]  imm_ext;
  logic [REG_W-1:0]  src_op;
  logic [REG_W-1:0]  sized_res;
  logic [REG_W-1:0]  merged;
  logic              f_zero, f_sign, f_parity;
  logic [FLAG_W-1:0] nxt_flags;
  logic              take;

  logic              vld_q;
  logic [REG_W-1:0]  res_q;
  logic [FLAG_W-1:0] flg_q;

  or_imm_extend #(.W(REG_W), .IW(IMM_W)) u_ext (
    .imm(in_imm), .short_form(in_imm_short), .sext(in_sext),
    .size(in_size), .ext(imm_ext)
  );

  assign src_op = in_src_imm ? imm_ext : in_src;

  or_sized_core #(.W(REG_W)) u_core (
    .dst(in_dst), .src(src_op), .size(in_size), .hi_byte(in_hi_byte),
    .res(sized_res), .zero(f_zero), .sign(f_sign), .parity(f_parity)
  );

  or_reg_merge #(.W(REG_W)) u_merge (
    .dst(in_dst), .res(sized_res), .size(in_size), .hi_byte(in_hi_byte),
    .merged(merged)
  );

  always_comb begin
    nxt_flags            = in_flags;
    nxt_flags[FL_CARRY]  = 1'b0;
    nxt_flags[FL_OVER]   = 1'b0;
    nxt_flags[FL_ZERO]   = f_zero;
    nxt_flags[FL_SIGN]   = f_sign;
    nxt_flags[FL_PARITY] = f_parity;
  end

  assign in_ready = !vld_q || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      res_q <= '0;
      flg_q <= '0;
    end else begin
      if (take) begin
        vld_q <= 1'b1;
        res_q <= merged;
        flg_q <= nxt_flags;
      end else if (out_ready) begin
        vld_q <= 1'b0;
      end
    end
  end

  assign out_valid  = vld_q;
  assign out_result = res_q;
  assign out_flags  = flg_q;
endmodule

// File: rtl/or_exec_unit_chk.sv
module or_exec_unit_chk
  import or_exec_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        in_ready,
  input logic [63:0] in_dst,
  input logic [1:0]  in_size,
  input logic        in_hi_byte,
  input logic [5:0]  in_flags,
  input logic        out_valid,
  input logic        out_ready,
  input logic [63:0] out_result,
  input logic [5:0]  out_flags
);
  logic [1:0]  cap_size;
  logic        cap_hi;
  logic        cap_aux;
  logic [63:0] cap_dst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_size <= '0;
      cap_hi   <= 1'b0;
      cap_aux  <= 1'b0;
      cap_dst  <= '0;
    end else if (in_valid && in_ready) begin
      cap_size <= in_size;
      cap_hi   <= in_hi_byte;
      cap_aux  <= in_flags[FL_AUX];
      cap_dst  <= in_dst;
    end
  end

  function automatic logic [63:0] sized_view(input logic [63:0] v, input logic [1:0] sz, input logic hi);
    if (sz == OPSZ_8 && hi) return {56'd0, v[15:8]};
    return v & size_mask(sz);
  endfunction

  assert_cf_of_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (!out_flags[FL_CARRY] && !out_flags[FL_OVER]));

  assert_zero_sized_R4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_flags[FL_ZERO] == (sized_view(out_result, cap_size, cap_hi) == 64'd0)));

  assert_aux_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_flags[FL_AUX] == cap_aux));

  assert_upper_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && cap_size == OPSZ_16) |-> (out_result[63:16] == cap_dst[63:16]));

  assert_zero_fill_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && cap_size == OPSZ_32) |-> (out_result[63:32] == 32'd0));

  assert_hi_byte_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && cap_size == OPSZ_8 && cap_hi) |->
      (out_result[63:16] == cap_dst[63:16] && out_result[7:0] == cap_dst[7:0]));

  assert_accept_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_result) && $stable(out_flags)));

  assert_block_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);
endmodule

bind or_exec_unit or_exec_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_dst(in_dst), .in_size(in_size), .in_hi_byte(in_hi_byte),
  .in_flags(in_flags), .out_valid(out_valid), .out_ready(out_ready),
  .out_result(out_result), .out_flags(out_flags)
);

// File: tb/or_exec_unit_test.sv
`timescale 1ns/1ps
module or_exec_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [63:0] in_dst = '0;
  logic [63:0] in_src = '0;
  logic [31:0] in_imm = '0;
  logic        in_src_imm = 1'b0;
  logic        in_imm_short = 1'b0;
  logic        in_sext = 1'b0;
  logic [1:0]  in_size = '0;
  logic        in_hi_byte = 1'b0;
  logic [5:0]  in_flags = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [63:0] out_result;
  logic [5:0]  out_flags;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  or_exec_unit uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_dst(in_dst), .in_src(in_src), .in_imm(in_imm), .in_src_imm(in_src_imm),
    .in_imm_short(in_imm_short), .in_sext(in_sext), .in_size(in_size),
    .in_hi_byte(in_hi_byte), .in_flags(in_flags), .out_valid(out_valid),
    .out_ready(out_ready), .out_result(out_result), .out_flags(out_flags)
  );

  function automatic logic [63:0] mask_of(input logic [1:0] sz);
    case (sz)
      2'd0: return 64'hFF;
      2'd1: return 64'hFFFF;
      2'd2: return 64'hFFFF_FFFF;
      default: return '1;
    endcase
  endfunction

  function automatic logic [63:0] exp_src();
    logic [63:0] v;
    if (!in_src_imm) v = in_src;
    else if (in_imm_short)
      v = (in_sext && in_size != 2'd0) ? {{56{in_imm[7]}}, in_imm[7:0]} : {56'd0, in_imm[7:0]};
    else
      v = (in_size == 2'd3) ? {{32{in_imm[31]}}, in_imm} : {32'd0, in_imm};
    return v & mask_of(in_size);
  endfunction

  function automatic logic [63:0] exp_sized();
    logic [63:0] a;
    a = (in_size == 2'd0 && in_hi_byte) ? {56'd0, in_dst[15:8]} : (in_dst & mask_of(in_size));
    return a | exp_src();
  endfunction

  function automatic logic [63:0] exp_result();
    logic [63:0] r;
    r = exp_sized();
    case (in_size)
      2'd0: return in_hi_byte ? {in_dst[63:16], r[7:0], in_dst[7:0]} : {in_dst[63:8], r[7:0]};
      2'd1: return {in_dst[63:16], r[15:0]};
      2'd2: return {32'd0, r[31:0]};
      default: return r;
    endcase
  endfunction

  function automatic logic [5:0] exp_flags();
    logic [63:0] r;
    logic [5:0] f;
    int w;
    r = exp_sized();
    w = 8 << in_size;
    f = '0;
    f[2] = in_flags[2];
    f[3] = (r == 64'd0);
    f[4] = r[w-1];
    f[1] = ~^r[7:0];
    return f;
  endfunction

  task automatic check64(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_op(input string req, input int stall);
    logic [63:0] er;
    logic [5:0]  ef;
    er = exp_result();
    ef = exp_flags();
    @(negedge clk);
    in_valid  = 1'b1;
    out_ready = (stall == 0);
    @(negedge clk);
    in_valid = 1'b0;
    check64({req, " R10 valid"}, {63'd0, out_valid}, 64'd1);
    for (int k = 0; k < stall; k++) begin
      check64({req, " R11 ready low"}, {63'd0, in_ready}, 64'd0);
      check64({req, " R11 held"}, out_result, er);
      @(negedge clk);
    end
    check64({req, " result"}, out_result, er);
    check64({req, " flags R3 R4 R5 R6"}, {58'd0, out_flags}, {58'd0, ef});
    out_ready = 1'b1;
  endtask

  task automatic set_op(input logic [63:0] d, input logic [63:0] s, input logic [31:0] im,
                        input logic simm, input logic sh, input logic sx, input logic [1:0] sz,
                        input logic hi, input logic [5:0] fl);
    in_dst = d; in_src = s; in_imm = im; in_src_imm = simm; in_imm_short = sh;
    in_sext = sx; in_size = sz; in_hi_byte = hi; in_flags = fl;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(32'h5EED_0042);
    repeat (3) @(negedge clk);
    check64("R12 out_valid", {63'd0, out_valid}, 64'd0);
    check64("R12 in_ready", {63'd0, in_ready}, 64'd1);
    rst_n = 1'b1;

    set_op(64'h0, 64'h0, 32'h80, 1'b1, 1'b1, 1'b1, 2'd1, 1'b0, 6'h3F);
    run_op("R2 short sext 16", 0);
    check64("R2 short sext value", out_result, 64'hFF80);
    set_op(64'h0, 64'h0, 32'h80, 1'b1, 1'b1, 1'b0, 2'd2, 1'b0, 6'h00);
    run_op("R2 short zext 32", 0);
    check64("R2 short zext value", out_result, 64'h80);
    set_op(64'h0, 64'h0, 32'h8000_0000, 1'b1, 1'b0, 1'b0, 2'd3, 1'b0, 6'h00);
    run_op("R2 long 64", 0);
    check64("R2 long sext value", out_result, 64'hFFFF_FFFF_8000_0000);
    set_op(64'h0, 64'h0, 32'h80, 1'b1, 1'b1, 1'b1, 2'd3, 1'b0, 6'h00);
    run_op("R2 short sext 64", 0);
    check64("R4 sign at 64", {63'd0, out_flags[4]}, 64'd1);
    set_op('1, 64'h0, 32'h0, 1'b0, 1'b0, 1'b0, 2'd2, 1'b0, 6'h04);
    run_op("R8 zero fill", 0);
    check64("R8 upper", {32'd0, out_result[63:32]}, 64'd0);
    set_op(64'h1122_3344_5566_7788, 64'h80, 32'h0, 1'b0, 1'b0, 1'b0, 2'd0, 1'b1, 6'h00);
    run_op("R9 hi byte", 0);
    check64("R9 value", out_result, 64'h1122_3344_5566_F788);
    set_op(64'hABCD_0000_0000_0000, 64'h0, 32'h0, 1'b0, 1'b0, 1'b0, 2'd1, 1'b0, 6'h00);
    run_op("R4 zero sized", 0);
    check64("R4 zero flag", {63'd0, out_flags[3]}, 64'd1);
    check64("R7 upper kept", out_result, 64'hABCD_0000_0000_0000);
    set_op(64'h0, 64'h7, 32'h0, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 6'h04);
    run_op("R5 odd parity", 3);
    check64("R5 parity", {63'd0, out_flags[1]}, 64'd0);

    for (int i = 0; i < 400; i++) begin
      set_op({$urandom, $urandom}, {$urandom, $urandom}, $urandom,
             1'($urandom), 1'($urandom), 1'($urandom), 2'($urandom),
             1'($urandom), 6'($urandom));
      if ($urandom_range(0, 3) == 0) in_dst[15:0] = 16'h0;
      run_op("R1 random", $urandom_range(0, 2));
    end

    @(negedge clk);
    check64("R12 drained", {63'd0, out_valid}, 64'd0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule